// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

This block is a register-mapped timer peripheral built from several independent 32-bit down-counters that share one bus port, one interrupt-enable mask, one interrupt-pending register and one interrupt line. Each channel keeps a control word, an interval value and a live count.

The control word picks one of four tick-enable inputs as the channel's time base, together with a power-of-two divider for that base. It also chooses between free-running periodic operation and single-shot operation. Writing the control word with its load bit set copies the interval into the counter. Software can build an up-counting timestamp by inverting the count it reads back.

Turning a channel on or off does not act at once. The new enable state reaches the counter only after a fixed number of ticks of the channel's selected time base. Software that stops a channel therefore waits a few ticks before it treats the channel as idle.

Top module: `ivt_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Register map. Offset 0x00 is the interrupt-enable mask and 0x04 is the pending register, with bit n standing for channel n. For channel n, the control word sits at 0x10*n+0x10, the interval at 0x10*n+0x14 and the live count at 0x10*n+0x18. Control bits are: bit 0 enable, bit 1 load, bits 3:2 tick source, bits 6:4 divider exponent, bit 7 single-shot. The load bit always reads back 0. The live count is read-only, and writes to it are ignored.
- R3: A control write with the load bit set makes the count equal to the interval on the next clock.
- R4: A change of the enable bit reaches the counter only after 2 ticks of the selected source. After enable is set, the first decrement happens on the 3rd source tick. After enable is cleared, the counter still decrements on the next 2 source ticks and then stops.
- R5: With divider exponent p, the count moves once every 2^p source ticks. Once running, the first move comes on the 2^p-th source tick.
- R6: A channel ignores ticks on sources it has not selected. Channels count independently of one another.
- R7: When a counting tick arrives while the count is 1 (or 0), the channel expires and sets its pending bit. In periodic mode (bit 7 = 0) the count then reloads from the interval.
- R8: In single-shot mode an expiry sets the pending bit, clears the enable bit and leaves the count at 0. Later ticks change neither the count nor the pending bit.
- R9: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged.
- R10: `irq` is high exactly when some channel has both its pending bit and its enable-mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 4 | One-cycle tick enables, one for each time-base source |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench counts exactly how many source ticks an enable change swallows, in both directions. A design that applied enable at once, or stopped at once, would show a count one or two off. It steps a divided channel tick by tick to find the first decrement; an off-by-one divider or one that keeps its phase from before the start moves on the wrong tick. Single-shot expiry is followed by extra ticks and a pending clear, so a counter that wrapped to all-ones or kept firing is exposed. Pending-clear writes of 0, masked interrupts and ticks on unselected sources check that nothing changes where nothing should.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int CNT_W  = 32;
    localparam int DATA_W = 32;
    localparam int SRC_W  = 2;
    localparam int NSRC   = 1 << SRC_W;
    localparam int PRES_W = 3;
    localparam int DIV_W  = (1 << PRES_W) - 1;

    localparam logic [3:0] OFF_CTRL = 4'h0;
    localparam logic [3:0] OFF_INTV = 4'h4;
    localparam logic [3:0] OFF_CNT  = 4'h8;
    localparam int         A_IE     = 'h00;
    localparam int         A_ST     = 'h04;

    typedef struct packed {
        logic              oneshot;
        logic [PRES_W-1:0] pres;
        logic [SRC_W-1:0]  src;
        logic              reload;
        logic              en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [DIV_W-1:0] div_mask(input logic [PRES_W-1:0] p);
        return DIV_W'((1 << p) - 1);
    endfunction

endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              tick_in,
    input  logic [PRES_W-1:0] sel,
    output logic              tick_out
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    assign mask     = div_mask(sel);
    assign tick_out = tick_in && ((div_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_q <= '0;
        end else if (tick_in) begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int SYNC_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_tick,
    input  logic             ctrl_we,
    input  ctrl_t            ctrl_wd,
    input  logic             intv_we,
    input  logic [CNT_W-1:0] intv_wd,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] intv_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    localparam int SW = $clog2(SYNC_TICKS + 1);

    logic          run;
    logic [SW-1:0] sync_q;
    logic          src_t;
    logic          cnt_t;

    assign src_t  = src_tick[ctrl_q.src];
    assign expire = run && cnt_t && (cnt_q <= CNT_W'(1));

    ivt_prescaler u_pres (
        .clk      (clk),
        .rst      (rst),
        .clr      (!run),
        .tick_in  (src_t),
        .sel      (ctrl_q.pres),
        .tick_out (cnt_t)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            intv_q <= '0;
            cnt_q  <= '0;
            run    <= 1'b0;
            sync_q <= '0;
        end else begin
            // enable crosses into the counter after SYNC_TICKS source ticks
            if (ctrl_q.en == run) begin
                sync_q <= '0;
            end else if (src_t) begin
                if (sync_q == SW'(SYNC_TICKS - 1)) begin
                    run    <= ctrl_q.en;
                    sync_q <= '0;
                end else begin
                    sync_q <= sync_q + 1'b1;
                end
            end
            // counting and expiry
            if (run && cnt_t) begin
                if (expire) begin
                    if (ctrl_q.oneshot) begin
                        cnt_q     <= '0;
                        ctrl_q.en <= 1'b0;
                        run       <= 1'b0;
                    end else begin
                        cnt_q <= intv_q;
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            // bus writes take priority
            if (intv_we) begin
                intv_q <= intv_wd;
            end
            if (ctrl_we) begin
                ctrl_q        <= ctrl_wd;
                ctrl_q.reload <= 1'b0;
                if (ctrl_wd.reload) begin
                    cnt_q <= intv_q;
                end
            end
        end
    end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int NCH        = 2,
    parameter int ADDR_W     = 8,
    parameter int SYNC_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CS_W = ADDR_W - 4;

    logic [CS_W-1:0]            chsel;
    logic [3:0]                 off;
    logic [NCH-1:0]             ie;
    logic [NCH-1:0]             status;
    logic [NCH-1:0]             expire_v;
    logic [NCH-1:0]             ctrl_we_v;
    logic [NCH-1:0]             intv_we_v;
    ctrl_t                      ctrl_a [NCH];
    logic [NCH-1:0][CNT_W-1:0]  intv_a;
    logic [NCH-1:0][CNT_W-1:0]  cnt_a;
    logic [NCH-1:0]             st_clr;

    assign chsel = bus_addr[ADDR_W-1:4];
    assign off   = bus_addr[3:0];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit          = bus_we && (chsel == CS_W'(g + 1));
        assign ctrl_we_v[g] = hit && (off == OFF_CTRL);
        assign intv_we_v[g] = hit && (off == OFF_INTV);

        ivt_channel #(.SYNC_TICKS(SYNC_TICKS)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .src_tick (src_tick),
            .ctrl_we  (ctrl_we_v[g]),
            .ctrl_wd  (ctrl_t'(bus_wdata[CTRL_W-1:0])),
            .intv_we  (intv_we_v[g]),
            .intv_wd  (bus_wdata[CNT_W-1:0]),
            .ctrl_q   (ctrl_a[g]),
            .intv_q   (intv_a[g]),
            .cnt_q    (cnt_a[g]),
            .expire   (expire_v[g])
        );
    end

    assign st_clr = (bus_we && bus_addr == ADDR_W'(A_ST)) ? bus_wdata[NCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie     <= '0;
            status <= '0;
        end else begin
            if (bus_we && bus_addr == ADDR_W'(A_IE)) begin
                ie <= bus_wdata[NCH-1:0];
            end
            status <= (status & ~st_clr) | expire_v;
        end
    end

    assign irq = |(status & ie);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_IE)) begin
            bus_rdata = DATA_W'(ie);
        end else if (bus_addr == ADDR_W'(A_ST)) begin
            bus_rdata = DATA_W'(status);
        end
        for (int i = 0; i < NCH; i++) begin
            if (chsel == CS_W'(i + 1)) begin
                case (off)
                    OFF_CTRL: bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_a[i]};
                    OFF_INTV: bus_rdata = intv_a[i];
                    OFF_CNT:  bus_rdata = cnt_a[i];
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk
    import ivt_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_we,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [DATA_W-1:0]        bus_wdata,
    input logic                     irq,
    input logic [NCH-1:0]           ie,
    input logic [NCH-1:0]           status,
    input logic [NCH-1:0]           expire_v,
    input logic [NCH-1:0]           ctrl_we_v,
    input logic [NCH-1:0][CNT_W-1:0] intv_a,
    input logic [NCH-1:0][CNT_W-1:0] cnt_a
);
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (ie == '0) |-> !irq); // R10
    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        (status == '0) |-> !irq); // R10

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_EXPIRE_PENDS: assert property (@(posedge clk) disable iff (rst)
            expire_v[g] |=> status[g]); // R7
        AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (rst)
            $rose(status[g]) |-> $past(expire_v[g])); // R7
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == ADDR_W'(A_ST) && bus_wdata[g] && !expire_v[g])
            |=> !status[g]); // R9
        AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
            (ctrl_we_v[g] && bus_wdata[1]) |=> (cnt_a[g] == $past(intv_a[g]))); // R3
    end
endmodule

bind ivt_timer ivt_timer_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .ie        (ie),
    .status    (status),
    .expire_v  (expire_v),
    .ctrl_we_v (ctrl_we_v),
    .intv_a    (intv_a),
    .cnt_a     (cnt_a)
);

// File: tb/ivt_timer_bench.sv
module ivt_timer_bench;
    import ivt_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NSRC-1:0]   src_tick = '0;
    logic              bus_we = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;

    int n_tests = 0;
    int n_fail  = 0;
    logic mon_req = 1'b0;
    bit   done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    ivt_timer u_ivt_timer (
        .clk       (clk),
        .rst       (rst),
        .src_tick  (src_tick),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // monitor: pops expected items and compares mid-cycle
    always @(negedge clk) begin
        if (mon_req && exp_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = exp_q.pop_front();
            act = it.is_irq ? {31'b0, irq} : bus_rdata;
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h",
                         it.tag, it.addr, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        mon_req = 1'b1;
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.is_irq = 1'b1; it.addr = 8'h00; it.exp = {31'b0, e}; it.tag = tag;
        exp_q.push_back(it);
        mon_req = 1'b1;
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic tk(input logic [NSRC-1:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            src_tick = m;
            @(posedge clk); #1;
            src_tick = '0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog req=all actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset values
        expect_rd(8'h00, 32'h0, "R1 ie");
        expect_rd(8'h04, 32'h0, "R1 status");
        expect_rd(8'h10, 32'h0, "R1 ctrl0");
        expect_rd(8'h18, 32'h0, "R1 cnt0");
        expect_irq(1'b0, "R1 irq");

        // R2 map and readback, R3 load
        wr(8'h14, 32'd5);
        expect_rd(8'h14, 32'd5, "R2 intv0");
        wr(8'h10, 32'h07);                  // en, load, source 1
        expect_rd(8'h10, 32'h05, "R2 ctrl0 load reads 0");
        expect_rd(8'h18, 32'd5, "R3 loaded cnt0");

        // R4 start delay
        tk(4'b0010, 2);
        expect_rd(8'h18, 32'd5, "R4 no count during sync");
        tk(4'b0010, 1);
        expect_rd(8'h18, 32'd4, "R4 first decrement");

        // R6 unselected source
        tk(4'b0001, 3);
        expect_rd(8'h18, 32'd4, "R6 wrong source ignored");

        // R7 periodic expiry
        tk(4'b0010, 3);
        expect_rd(8'h18, 32'd1, "R7 before expiry");
        tk(4'b0010, 1);
        expect_rd(8'h04, 32'h1, "R7 pending set");
        expect_rd(8'h18, 32'd5, "R7 reloaded");
        expect_irq(1'b0, "R10 masked");
        wr(8'h00, 32'h1);
        expect_irq(1'b1, "R10 unmasked");

        // R9 write-one-to-clear
        wr(8'h04, 32'h0);
        expect_rd(8'h04, 32'h1, "R9 write 0 keeps");
        wr(8'h04, 32'h1);
        expect_rd(8'h04, 32'h0, "R9 write 1 clears");
        expect_irq(1'b0, "R10 cleared");

        // R4 stop delay
        wr(8'h10, 32'h04);
        expect_rd(8'h10, 32'h04, "R2 ctrl0 disabled");
        tk(4'b0010, 2);
        expect_rd(8'h18, 32'd3, "R4 counts through stop delay");
        tk(4'b0010, 2);
        expect_rd(8'h18, 32'd3, "R4 stopped");

        // R5 prescaler, exponent 2
        wr(8'h14, 32'd10);
        wr(8'h10, 32'h27);
        expect_rd(8'h10, 32'h25, "R2 ctrl0 with divider");
        tk(4'b0010, 5);
        expect_rd(8'h18, 32'd10, "R5 no move before 4th tick");
        tk(4'b0010, 1);
        expect_rd(8'h18, 32'd9, "R5 first divided move");
        tk(4'b0010, 4);
        expect_rd(8'h18, 32'd8, "R5 second divided move");

        // R2 count is read-only
        wr(8'h18, 32'hFF);
        expect_rd(8'h18, 32'd8, "R2 count write ignored");

        // R8 single shot on channel 1, source 2
        wr(8'h24, 32'd3);
        wr(8'h20, 32'h8B);
        expect_rd(8'h20, 32'h89, "R2 ctrl1");
        expect_rd(8'h28, 32'd3, "R3 loaded cnt1");
        tk(4'b0100, 4);
        expect_rd(8'h28, 32'd1, "R8 before expiry");
        tk(4'b0100, 1);
        expect_rd(8'h28, 32'd0, "R8 count at zero");
        expect_rd(8'h04, 32'h2, "R8 pending set");
        expect_rd(8'h20, 32'h88, "R8 enable cleared");
        expect_irq(1'b0, "R10 other channel masked");
        wr(8'h00, 32'h3);
        expect_irq(1'b1, "R10 channel 1 unmasked");
        tk(4'b0100, 3);
        expect_rd(8'h28, 32'd0, "R8 holds zero");
        wr(8'h04, 32'h2);
        tk(4'b0100, 2);
        expect_rd(8'h04, 32'h0, "R8 no refire");
        expect_irq(1'b0, "R10 idle");
        expect_rd(8'h18, 32'd8, "R6 channel 0 untouched");

        done = 1'b1;
        @(posedge clk); #1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule